// File: doc/BRIEF.md
# Edge-Interrupt GPIO Controller

A sixteen-line general-purpose I/O block sitting on a small memory-mapped register bus. Each line is individually configured as an input or an output. Output lines drive the value held in an output data register. Input lines are brought into the clock domain through a synchronizer and can raise a per-line interrupt on either a rising or a falling transition.

Interrupt events are recorded in a status register. An interrupt only registers for a line that is an input and is not masked. Software acknowledges events by writing ones to the status register. A single level interrupt output stays high while any status bit is set. The output data register keeps its full contents while a line is an input, so the value is ready the moment the line is switched to output.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset, output data, direction, edge select and mask read as 0xFFFF, input data and status read as 0x0000, all lines are inputs (`pin_oe_o` = 0) and `irq_o` is low.
- R2: The registers sit at byte offsets 0x00 input data, 0x04 output data, 0x08 direction, 0x0C edge select, 0x10 mask and 0x14 status. A read strobe returns data on `rdata_o` one clock later. An unmapped offset reads as zero, and `rdata_o` is zero in any cycle that does not follow a read strobe.
- R3: A direction bit of 1 makes the line an input and 0 makes it an output. `pin_oe_o` is the inverse of direction, and `pin_o` carries the output data bit only where the line is an output, and 0 elsewhere.
- R4: A write to output data stores all 16 bits, even for input lines. A later change of direction to output drives the stored value on the next clock.
- R5: `pin_i` passes through two synchronizing flops. The input data register shows the pin value two clocks after it changes, and a status bit is set on the third clock edge after the pin transition.
- R6: An edge select bit of 1 triggers on a rising transition of the synchronized input, and 0 triggers on a falling one.
- R7: A status bit is set only for a line whose direction bit is 1 and whose mask bit is 0.
- R8: Writing the status register clears each bit written as 1 and leaves bits written as 0 unchanged. `irq_o` is high while any status bit is set and low once all are clear.
- R9: When a new edge and a write-one clear hit the same status bit in the same cycle, the bit stays set.
- R10: Writes to the input data offset 0x00 and to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 8 | Register byte offset |
| we_i | input | 1 | Write strobe |
| re_i | input | 1 | Read strobe |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, one clock after the read strobe |
| pin_i | input | 16 | Asynchronous pin inputs |
| pin_o | output | 16 | Pin output values |
| pin_oe_o | output | 16 | Pin output enables, 1 = driven |
| irq_o | output | 1 | Level interrupt, high while any status bit is set |

## Verification
The hardest case to reach is a write-one clear that lands on the same clock edge as a fresh edge on the same line. Reaching it needs the stimulus to count the synchronizer latency exactly. The bench first leaves the status bit set. It then changes the pin on a falling clock edge and waits two clocks, so the status write is sampled on the third edge, the edge that records the new event. A per-cycle behavioural model is checked against the outputs on every clock, so the one-cycle timing of the synchronizer, the status update and the read data are all pinned down.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned LINES  = 16;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned SYNC_N = 2;

  localparam int unsigned OFF_DIN  = 'h00;
  localparam int unsigned OFF_DOUT = 'h04;
  localparam int unsigned OFF_DIR  = 'h08;
  localparam int unsigned OFF_EDGE = 'h0C;
  localparam int unsigned OFF_MASK = 'h10;
  localparam int unsigned OFF_STAT = 'h14;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_DIN, SEL_DOUT, SEL_DIR, SEL_EDGE, SEL_MASK, SEL_STAT
  } reg_sel_e;
endpackage

// File: rtl/gpio_edge_sync.sv
module gpio_edge_sync #(
  parameter int unsigned N      = gpio_edge_pkg::LINES,
  parameter int unsigned STAGES = gpio_edge_pkg::SYNC_N
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] din_o,
  output logic [N-1:0] prev_o
);
  logic [STAGES-1:0][N-1:0] stg_q;
  logic [N-1:0]             prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= pin_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  // one-cycle-old copy for edge detection
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= stg_q[STAGES-1];
  end

  assign din_o  = stg_q[STAGES-1];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_edge_regs.sv
module gpio_edge_regs
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N  = LINES,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [N-1:0]  wdata_i,
  input  logic [N-1:0]  din_i,
  input  logic [N-1:0]  stat_i,
  output logic [N-1:0]  rdata_o,
  output logic [N-1:0]  dout_o,
  output logic [N-1:0]  dir_o,
  output logic [N-1:0]  edge_o,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  clr_o
);
  reg_sel_e     sel;
  logic [N-1:0] dout_q, dir_q, edge_q, mask_q, rdata_q, rd_mux;

  always_comb begin
    unique case (addr_i)
      AW'(OFF_DIN):  sel = SEL_DIN;
      AW'(OFF_DOUT): sel = SEL_DOUT;
      AW'(OFF_DIR):  sel = SEL_DIR;
      AW'(OFF_EDGE): sel = SEL_EDGE;
      AW'(OFF_MASK): sel = SEL_MASK;
      AW'(OFF_STAT): sel = SEL_STAT;
      default:       sel = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q <= '1;
      dir_q  <= '1;
      edge_q <= '1;
      mask_q <= '1;
    end else if (we_i) begin
      case (sel)
        SEL_DOUT: dout_q <= wdata_i;
        SEL_DIR:  dir_q  <= wdata_i;
        SEL_EDGE: edge_q <= wdata_i;
        SEL_MASK: mask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  assign clr_o = (we_i && sel == SEL_STAT) ? wdata_i : '0;

  always_comb begin
    case (sel)
      SEL_DIN:  rd_mux = din_i;
      SEL_DOUT: rd_mux = dout_q;
      SEL_DIR:  rd_mux = dir_q;
      SEL_EDGE: rd_mux = edge_q;
      SEL_MASK: rd_mux = mask_q;
      SEL_STAT: rd_mux = stat_i;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= re_i ? rd_mux : '0;
  end

  assign rdata_o = rdata_q;
  assign dout_o  = dout_q;
  assign dir_o   = dir_q;
  assign edge_o  = edge_q;
  assign mask_o  = mask_q;

  // R10
  ro_write_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && (sel == SEL_DIN || sel == SEL_NONE)) |=>
      $stable({dout_q, dir_q, edge_q, mask_q}));

  // R2
  unmapped_read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && sel == SEL_NONE) |=> (rdata_o == '0));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
  parameter int unsigned N = gpio_edge_pkg::LINES
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] din_i,
  input  logic [N-1:0] prev_i,
  input  logic [N-1:0] dir_i,
  input  logic [N-1:0] edge_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] stat_o,
  output logic         irq_o
);
  logic [N-1:0] hit, stat_q;

  for (genvar i = 0; i < N; i++) begin : g_line
    logic trig;
    assign trig   = edge_i[i] ? (din_i[i] & ~prev_i[i]) : (~din_i[i] & prev_i[i]);
    assign hit[i] = trig & dir_i[i] & ~mask_i[i];

    // set beats clear on collision
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     stat_q[i] <= 1'b0;
      else if (hit[i]) stat_q[i] <= 1'b1;
      else if (clr_i[i]) stat_q[i] <= 1'b0;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;

  // R7
  stat_qualified_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & ~$past(stat_q) & ~$past(dir_i & ~mask_i)) == '0));

  // R8
  stat_cleared_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(clr_i & ~hit)) == '0));

  // R9
  edge_beats_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((stat_q & $past(hit)) == $past(hit)));
endmodule

// File: rtl/gpio_edge_ctrl.sv
module gpio_edge_ctrl
  import gpio_edge_pkg::*;
#(
  parameter int unsigned N  = LINES,
  parameter int unsigned AW = ADDR_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          we_i,
  input  logic          re_i,
  input  logic [N-1:0]  wdata_i,
  output logic [N-1:0]  rdata_o,
  input  logic [N-1:0]  pin_i,
  output logic [N-1:0]  pin_o,
  output logic [N-1:0]  pin_oe_o,
  output logic          irq_o
);
  logic [N-1:0] din, prev, dout, dir, edge_sel, mask, clr, stat;

  gpio_edge_sync #(.N(N), .STAGES(SYNC_N)) i_sync (
    .clk_i, .rst_ni, .pin_i, .din_o(din), .prev_o(prev)
  );

  gpio_edge_regs #(.N(N), .AW(AW)) i_regs (
    .clk_i, .rst_ni, .addr_i, .we_i, .re_i, .wdata_i,
    .din_i(din), .stat_i(stat), .rdata_o,
    .dout_o(dout), .dir_o(dir), .edge_o(edge_sel), .mask_o(mask), .clr_o(clr)
  );

  gpio_edge_irq #(.N(N)) i_irq (
    .clk_i, .rst_ni, .din_i(din), .prev_i(prev), .dir_i(dir),
    .edge_i(edge_sel), .mask_i(mask), .clr_i(clr), .stat_o(stat), .irq_o
  );

  assign pin_oe_o = ~dir;
  assign pin_o    = dout & ~dir;
endmodule

// File: tb/test_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module test_gpio_edge_ctrl;
  logic        clk = 0, rst_n = 0;
  logic [7:0]  addr = 0;
  logic        we = 0, re = 0;
  logic [15:0] wdata = 0, pin = 0;
  logic [15:0] rdata, pin_o, pin_oe;
  logic        irq;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_edge_ctrl i_gpio_edge_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .we_i(we), .re_i(re),
    .wdata_i(wdata), .rdata_o(rdata), .pin_i(pin), .pin_o(pin_o),
    .pin_oe_o(pin_oe), .irq_o(irq)
  );

  // behavioural reference
  logic [15:0] m_s1, m_s2, m_prev, m_out, m_dir, m_edge, m_mask, m_st, m_rd;
  always @(posedge clk or negedge rst_n) begin
    logic [15:0] hit, clr, rdv;
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_prev = 0; m_st = 0; m_rd = 0;
      m_out = 16'hFFFF; m_dir = 16'hFFFF; m_edge = 16'hFFFF; m_mask = 16'hFFFF;
    end else begin
      hit = ((m_edge & m_s2 & ~m_prev) | (~m_edge & ~m_s2 & m_prev)) & m_dir & ~m_mask;
      clr = (we && addr == 8'h14) ? wdata : 16'h0;
      case (addr)
        8'h00: rdv = m_s2;   8'h04: rdv = m_out;  8'h08: rdv = m_dir;
        8'h0C: rdv = m_edge; 8'h10: rdv = m_mask; 8'h14: rdv = m_st;
        default: rdv = 0;
      endcase
      m_rd = re ? rdv : 16'h0;
      m_st = (m_st & ~clr) | hit;
      if (we) case (addr)
        8'h04: m_out = wdata;   8'h08: m_dir = wdata;
        8'h0C: m_edge = wdata;  8'h10: m_mask = wdata;
        default: ;
      endcase
      m_prev = m_s2; m_s2 = m_s1; m_s1 = pin;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // per-cycle comparison
  always @(negedge clk) if (rst_n && !done) begin
    check(rdata == m_rd, "R2 rdata", rdata, m_rd);
    check(pin_o == (m_out & ~m_dir), "R3 pin_o", pin_o, m_out & ~m_dir);
    check(pin_oe == ~m_dir, "R3 pin_oe", pin_oe, ~m_dir);
    check(irq == (m_st != 0), "R8 irq", {15'b0, irq}, {15'b0, m_st != 0});
  end

  // tasks assume entry at a negedge
  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [15:0] exp, input string tag);
    addr = a; re = 1;
    @(negedge clk); re = 0;
    #1 check(rdata == exp, tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(pin_oe == 0, "R1 pin_oe", pin_oe, 0);
    check(irq == 0, "R1 irq", {15'b0, irq}, 0);
    rd(8'h00, 16'h0000, "R1 din");
    rd(8'h04, 16'hFFFF, "R1 dout");
    rd(8'h08, 16'hFFFF, "R1 dir");
    rd(8'h0C, 16'hFFFF, "R1 edge");
    rd(8'h10, 16'hFFFF, "R1 mask");
    rd(8'h14, 16'h0000, "R1 stat");
    // R4 output data held while input
    wr(8'h04, 16'h1234);
    check(pin_o == 0, "R4 pin_o while input", pin_o, 0);
    rd(8'h04, 16'h1234, "R4 dout stored");
    wr(8'h08, 16'hFF00);
    check(pin_o == 16'h0034, "R4 pin_o after dir", pin_o, 16'h0034);
    check(pin_oe == 16'h00FF, "R3 pin_oe", pin_oe, 16'h00FF);
    // R10 ignored writes
    wr(8'h00, 16'hAAAA);
    wr(8'h18, 16'h0000);
    wr(8'h02, 16'h0000);
    rd(8'h04, 16'h1234, "R10 dout kept");
    rd(8'h08, 16'hFF00, "R10 dir kept");
    rd(8'h00, 16'h0000, "R10 din kept");
    rd(8'h18, 16'h0000, "R2 unmapped read");
    // R5 synchronizer latency
    pin = 16'h0100; idle(3);
    rd(8'h00, 16'h0100, "R5 din settled");
    pin = 16'h0300;
    rd(8'h00, 16'h0100, "R5 din delayed");
    idle(2);
    rd(8'h00, 16'h0300, "R5 din updated");
    rd(8'h14, 16'h0000, "R7 masked edge");
    // R7 qualification
    wr(8'h10, 16'h0000);
    pin = 16'h0000; idle(4);
    rd(8'h14, 16'h0000, "R6 falls ignored on rising select");
    pin = 16'h0101; idle(4);
    rd(8'h14, 16'h0100, "R7 only input line");
    check(irq == 1, "R8 irq set", {15'b0, irq}, 1);
    // R8 write-one clear
    wr(8'h14, 16'h0001);
    check(irq == 1, "R8 zero bits kept", {15'b0, irq}, 1);
    wr(8'h14, 16'h0100);
    check(irq == 0, "R8 irq cleared", {15'b0, irq}, 0);
    rd(8'h14, 16'h0000, "R8 stat cleared");
    // R6 falling select
    wr(8'h0C, 16'hFEFF);
    pin = 16'h0001; idle(4);
    rd(8'h14, 16'h0100, "R6 falling edge");
    pin = 16'h0101; idle(4);
    rd(8'h14, 16'h0100, "R6 rising ignored");
    // R9 collision: edge recorded on third edge, clear sampled there too
    pin = 16'h0001; idle(2);
    wr(8'h14, 16'h0100);
    rd(8'h14, 16'h0100, "R9 edge wins");
    wr(8'h14, 16'h0100);
    rd(8'h14, 16'h0000, "R9 cleared after");
    // R5 status timing: set on third edge
    pin = 16'h0101; idle(4);
    pin = 16'h0001; idle(2);
    check(irq == 0, "R5 before third edge", {15'b0, irq}, 0);
    idle(1);
    check(irq == 1, "R5 at third edge", {15'b0, irq}, 1);
    idle(2);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule